// File: doc/BRIEF.md
# Quad SPI Flash Read Slave with Continuous Execute-in-Place

This block is the read side of a serial flash device. A bus master selects it with an active-low chip select, clocks it with SCK and exchanges data over a 4-bit bidirectional bus. Two read commands are recognised. The quad-output read takes its address on one line and returns data on all four. The quad I/O read takes its address on all four lines and carries a mode byte. That byte can put the device into a continuous mode, in which later frames leave out the opcode and begin with the address. The bus width therefore changes partway through a frame, and it can also change from one frame to the next.

SCK, chip select and the data lines are sampled in the system clock domain, which must run at least four times faster than SCK. The block takes input bits on SCK rising edges and changes its outputs on SCK falling edges. The byte storage is loaded through a simple write port before reads begin. An external write-in-progress flag replaces outgoing read data with zeros.

Top module: `quad_xip_reader`

## Requirements
- R1: During reset and after it, all output enables are low. The first frame after reset starts with an opcode on a single line.
- R2: An opcode is 8 bits, taken most significant bit first from dq_in[0] on eight consecutive SCK rising edges.
- R3: Opcode 0x6B takes a 24-bit address on dq_in[0], most significant bit first, then 8 SCK clocks whose inputs are ignored. After that it returns one byte per two SCK clocks on dq_out, high nibble first.
- R4: Opcode 0xEB takes a 24-bit address as 6 nibbles on dq_in[3:0], most significant nibble first. Two clocks then carry the mode byte, high nibble first, followed by 6 ignored clocks. Data follows in the same form as R3.
- R5: dq_out and dq_oe change only in the system clock cycle after an SCK falling edge, with one exception: when chip select goes high, the enables go low on the next clock. The enables are high only during the data phase of a frame, never during opcode, address, mode or dummy clocks.
- R6: The read address increments after each byte. Only the low ADDR_W address bits are used, so reads wrap from the top of storage to address 0.
- R7: If bit 4 of the mode byte of a 0xEB frame is 0 (dq_in[0] on the first mode clock), raising chip select enters continuous mode. The next frame then begins at once with the 6 address nibbles, followed by mode, dummy and data as in R4. The mode bit of that frame again decides whether continuous mode is kept.
- R8: If that mode bit is 1, or the frame was a 0x6B read, the next frame begins with an opcode.
- R9: While wip is high at an SCK falling edge in the data phase, the nibble driven is 0 with the enables still high. The address still advances.
- R10: Any other opcode leaves the enables low for the rest of the frame, and the next frame begins with an opcode.
- R11: If chip select rises before the mode nibble of a frame has been taken, continuous mode is left.
- R12: A pulse on ld_en writes ld_data into storage at ld_addr, and later reads return that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x SCK |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| dq_in | input | 4 | Data lines as seen at the pads |
| dq_out | output | 4 | Data driven onto the lines |
| dq_oe | output | 4 | Per-line output enable |
| wip | input | 1 | Write in progress; blanks read data |
| ld_en | input | 1 | Storage load strobe |
| ld_addr | input | ADDR_W | Storage load address |
| ld_data | input | 8 | Storage load byte |

## Verification
The bench builds the block with ADDR_W = 8, which gives 256 bytes of storage. This puts the wrap from 0xFF to 0x00 within a five-byte read. A start address with nonzero upper bits then shows that those bits are dropped. The bench runs a reference model of the enables and nibbles that is advanced by the frames it drives, and compares against the block on every clock. Chains of continuous-mode frames, a frame cut short in its address phase, and wip toggled between bytes show how the mode and address state carry across frame and byte boundaries.

// File: rtl/qxr_pkg.sv
// Shared definitions for the quad read slave.
// Assumes nothing beyond IEEE 1800-2017 packages.
package qxr_pkg;
    // Frame phases of the read sequencer.
    typedef enum logic [2:0] {
        PH_OPC  = 3'd0,
        PH_ADDR = 3'd1,
        PH_WAIT = 3'd2,
        PH_DATA = 3'd3,
        PH_SKIP = 3'd4
    } rd_phase_e;

    localparam logic [7:0] OPC_QUAD_OUT = 8'h6B;
    localparam logic [7:0] OPC_QUAD_IO  = 8'hEB;
    localparam int ADDR_BITS  = 24;
    localparam int OPC_BITS   = 8;
    localparam int WAIT_CLKS  = 8;
    localparam int CNT_W      = 5;
endpackage

// File: rtl/qxr_edge.sv
// Edge detector for SCK and chip select in the system clock domain.
// Assumes sck and cs_n are already synchronous to clk (synchronised
// upstream) and that SCK stays at each level for at least two clk cycles.
module qxr_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    // Keep the previous levels for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Edge pulses, one clk cycle wide.
    always_comb begin
        sck_rise = sck & ~sck_q;
        sck_fall = ~sck & sck_q;
        cs_rise  = cs_n & ~cs_q;
    end
endmodule

// File: rtl/qxr_seq.sv
// Frame sequencer: opcode decode, address capture on one or four lines,
// mode bit capture, dummy counting, data-phase byte stepping and the
// continuous-mode flag kept across chip-select frames.
// Assumes chip select stays high for at least two clk cycles between frames.
module qxr_seq
    import qxr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck_rise,
    input  logic              cs_rise,
    input  logic [3:0]        dq_in,
    output logic              data_phase,
    output logic              nib_low,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int QADDR_CLKS = ADDR_BITS / 4;
    localparam logic [CNT_W-1:0] OPC_LAST   = CNT_W'(OPC_BITS - 1);
    localparam logic [CNT_W-1:0] SADDR_LAST = CNT_W'(ADDR_BITS - 1);
    localparam logic [CNT_W-1:0] QADDR_LAST = CNT_W'(QADDR_CLKS - 1);
    localparam logic [CNT_W-1:0] WAIT_LAST  = CNT_W'(WAIT_CLKS - 1);

    rd_phase_e              phase_q;
    logic [CNT_W-1:0]       cnt_q;
    logic [ADDR_BITS-1:0]   sr_q;
    logic                   quad_q;
    logic                   io_q;
    logic                   xip_q;
    logic                   mode_valid_q;
    logic                   mode_bit_q;
    logic                   nib_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [ADDR_BITS-1:0]   sr_nxt;
    logic [OPC_BITS-1:0]    opc_nxt;

    // Next shift-register value for a one-line or four-line clock.
    always_comb begin
        if (quad_q && phase_q == PH_ADDR)
            sr_nxt = {sr_q[ADDR_BITS-5:0], dq_in};
        else
            sr_nxt = {sr_q[ADDR_BITS-2:0], dq_in[0]};
        opc_nxt = sr_nxt[OPC_BITS-1:0];
    end

    // Frame state machine advanced on SCK rising edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q      <= PH_OPC;
            cnt_q        <= '0;
            sr_q         <= '0;
            quad_q       <= 1'b0;
            io_q         <= 1'b0;
            xip_q        <= 1'b0;
            mode_valid_q <= 1'b0;
            mode_bit_q   <= 1'b1;
            nib_q        <= 1'b0;
            addr_q       <= '0;
        end else if (cs_n) begin
            phase_q <= xip_q ? PH_ADDR : PH_OPC;
            quad_q  <= xip_q;
            io_q    <= xip_q;
            cnt_q   <= '0;
            nib_q   <= 1'b0;
            if (cs_rise) begin
                xip_q        <= io_q & mode_valid_q & ~mode_bit_q;
                mode_valid_q <= 1'b0;
            end
        end else if (sck_rise) begin
            case (phase_q)
                PH_OPC: begin
                    sr_q  <= sr_nxt;
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == OPC_LAST) begin
                        cnt_q <= '0;
                        if (opc_nxt == OPC_QUAD_IO) begin
                            phase_q <= PH_ADDR;
                            quad_q  <= 1'b1;
                            io_q    <= 1'b1;
                        end else if (opc_nxt == OPC_QUAD_OUT) begin
                            phase_q <= PH_ADDR;
                            quad_q  <= 1'b0;
                            io_q    <= 1'b0;
                        end else begin
                            phase_q <= PH_SKIP;
                        end
                    end
                end
                PH_ADDR: begin
                    sr_q  <= sr_nxt;
                    cnt_q <= cnt_q + 1'b1;
                    if ((quad_q && cnt_q == QADDR_LAST) ||
                        (!quad_q && cnt_q == SADDR_LAST)) begin
                        addr_q  <= sr_nxt[ADDR_W-1:0];
                        phase_q <= PH_WAIT;
                        cnt_q   <= '0;
                    end
                end
                PH_WAIT: begin
                    cnt_q <= cnt_q + 1'b1;
                    // Bit 4 of the mode byte sits on line 0 of the first clock.
                    if (io_q && cnt_q == '0) begin
                        mode_bit_q   <= dq_in[0];
                        mode_valid_q <= 1'b1;
                    end
                    if (cnt_q == WAIT_LAST) begin
                        phase_q <= PH_DATA;
                        cnt_q   <= '0;
                        nib_q   <= 1'b0;
                    end
                end
                PH_DATA: begin
                    nib_q <= ~nib_q;
                    if (nib_q)
                        addr_q <= addr_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Outputs toward storage and the line driver.
    always_comb begin
        data_phase = (phase_q == PH_DATA) && !cs_n;
        nib_low    = nib_q;
        rd_addr    = addr_q;
    end

    // R2
    opc_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_OPC) |-> (cnt_q < CNT_W'(OPC_BITS)));

    // R7
    xip_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && xip_q) |=> (phase_q == PH_ADDR) && quad_q);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && sck_rise && phase_q == PH_DATA && nib_q)
        |=> (addr_q == $past(addr_q) + 1'b1));

    // R10
    skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && phase_q == PH_SKIP) |=> (phase_q == PH_SKIP) || cs_n);
endmodule

// File: rtl/qxr_store.sv
// Byte storage of 2**ADDR_W entries: one synchronous load port and one
// asynchronous read port. Assumes the contents are loaded before reads.
module qxr_store #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem [DEPTH];

    // Load port.
    always_ff @(posedge clk) begin
        if (ld_en)
            mem[ld_addr] <= ld_data;
    end

    // Read port.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/qxr_drive.sv
// Line driver: on an SCK falling edge in the data phase it drives the next
// nibble, high half first, or zero while a write is in progress. All enables
// are released the clk cycle after chip select is seen high.
module qxr_drive #(
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sck_fall,
    input  logic             data_phase,
    input  logic             nib_low,
    input  logic             wip,
    input  logic [7:0]       rd_data,
    output logic [LANES-1:0] dq_out,
    output logic [LANES-1:0] dq_oe
);
    logic             oe_q;
    logic [LANES-1:0] out_q;

    // Update the driven nibble and enable on falling SCK edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_q  <= 1'b0;
            out_q <= '0;
        end else if (cs_n) begin
            oe_q <= 1'b0;
        end else if (sck_fall && data_phase) begin
            oe_q  <= 1'b1;
            out_q <= wip ? '0 : (nib_low ? rd_data[3:0] : rd_data[7:4]);
        end
    end

    // Fan the single enable out to every lane.
    always_comb begin
        dq_out = out_q;
        for (int i = 0; i < LANES; i++)
            dq_oe[i] = oe_q;
    end

    // R5
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (dq_oe == '0));

    // R5
    oe_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq_oe != '0) |-> (data_phase || cs_n));

    // R5
    out_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sck_fall |=> $stable(dq_out));
endmodule

// File: rtl/quad_xip_reader.sv
// Top of the quad read slave with continuous execute-in-place mode.
// Assumes clk runs at least 4x SCK, sck/cs_n are synchronous to clk,
// and ADDR_W does not exceed 24.
module quad_xip_reader #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic [3:0]        dq_in,
    output logic [3:0]        dq_out,
    output logic [3:0]        dq_oe,
    input  logic              wip,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [7:0]        ld_data
);
    logic              sck_rise;
    logic              sck_fall;
    logic              cs_rise;
    logic              data_phase;
    logic              nib_low;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;

    qxr_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_rise  (cs_rise)
    );

    qxr_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck_rise   (sck_rise),
        .cs_rise    (cs_rise),
        .dq_in      (dq_in),
        .data_phase (data_phase),
        .nib_low    (nib_low),
        .rd_addr    (rd_addr)
    );

    qxr_store #(.ADDR_W(ADDR_W)) u_store (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    qxr_drive #(.LANES(4)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .sck_fall   (sck_fall),
        .data_phase (data_phase),
        .nib_low    (nib_low),
        .wip        (wip),
        .rd_data    (rd_data),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );
endmodule

// File: tb/quad_xip_reader_bench.sv
module quad_xip_reader_bench;
    localparam int AW = 8;
    localparam int H  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          sck = 1'b0;
    logic [3:0]    dq_in = '0;
    logic [3:0]    dq_out;
    logic [3:0]    dq_oe;
    logic          wip = 1'b0;
    logic          ld_en = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [7:0]    ld_data = '0;

    int total = 0;
    int bad = 0;
    logic       chk_on = 1'b0;
    logic       exp_oe = 1'b0;
    logic [3:0] exp_nib = '0;
    string      cur_tag = "R1";
    bit         xip_m = 1'b0;
    logic [7:0] mem_m [256];

    always #4 clk = ~clk;

    quad_xip_reader #(.ADDR_W(AW)) u_quad_xip_reader (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
        .dq_out(dq_out), .dq_oe(dq_oe), .wip(wip), .ld_en(ld_en),
        .ld_addr(ld_addr), .ld_data(ld_data)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-clock comparison with the reference enable and nibble (R5).
    always @(posedge clk) begin
        #2;
        if (chk_on) begin
            total++;
            if (dq_oe !== {4{exp_oe}}) begin
                bad++;
                $display("FAIL R5 enable: actual=%h expected=%h", dq_oe, {4{exp_oe}});
            end else if (exp_oe && dq_out !== exp_nib) begin
                bad++;
                $display("FAIL %s nibble: actual=%h expected=%h", cur_tag, dq_out, exp_nib);
            end
        end
    end

    task automatic tick(input logic [3:0] d);
        sck = 1'b0; dq_in = d;
        repeat (H) @(negedge clk);
        sck = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic data_clk(input logic [3:0] e, input bit w);
        sck = 1'b0; dq_in = '0; wip = w; exp_oe = 1'b1; exp_nib = e;
        repeat (H) @(negedge clk);
        check(cur_tag, {28'd0, dq_out}, {28'd0, e});
        sck = 1'b1;
        repeat (H) @(negedge clk);
    endtask

    task automatic end_frame();
        cs_n = 1'b1; exp_oe = 1'b0;
        @(negedge clk);
        sck = 1'b0; wip = 1'b0;
        repeat (4) @(negedge clk);
        check("R5", {28'd0, dq_oe}, 32'd0);
    endtask

    // One read frame; first nwip bytes are read with wip high.
    task automatic frame(input logic [7:0] op, input logic [23:0] a,
                         input logic [7:0] mode, input int nbytes, input int nwip);
        logic [7:0] kind;
        logic [AW-1:0] ad;
        kind = xip_m ? 8'hEB : op;
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        if (!xip_m)
            for (int i = 7; i >= 0; i--) tick({3'b000, op[i]});
        if (kind == 8'hEB) begin
            for (int i = 5; i >= 0; i--) tick(a[i*4 +: 4]);
            tick(mode[7:4]);
            tick(mode[3:0]);
            for (int i = 0; i < 6; i++) tick(4'h0);
        end else if (kind == 8'h6B) begin
            for (int i = 23; i >= 0; i--) tick({3'b000, a[i]});
            for (int i = 0; i < 8; i++) tick(4'h0);
        end else begin
            for (int i = 0; i < 20; i++) tick(4'hF);
            check("R10", {28'd0, dq_oe}, 32'd0);
        end
        if (kind == 8'hEB || kind == 8'h6B) begin
            ad = a[AW-1:0];
            for (int b = 0; b < nbytes; b++) begin
                bit w;
                logic [7:0] v;
                w = (b < nwip);
                v = w ? 8'h00 : mem_m[ad];
                data_clk(v[7:4], w);
                data_clk(v[3:0], w);
                ad = ad + 1'b1;
            end
        end
        end_frame();
        xip_m = (kind == 8'hEB) ? !mode[4] : 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: enables low during reset
        check("R1", {28'd0, dq_oe}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {28'd0, dq_oe}, 32'd0);
        chk_on = 1'b1;
        // R12: load storage through the write port
        for (int i = 0; i < 256; i++) begin
            mem_m[i] = 8'((i * 29 + 7) ^ (i >> 3));
            ld_en = 1'b1; ld_addr = AW'(i); ld_data = mem_m[i];
            @(negedge clk);
        end
        ld_en = 1'b0;
        @(negedge clk);
        cur_tag = "R12 R1";
        frame(8'h6B, 24'h000000, 8'h00, 3, 0);
        cur_tag = "R2 R3";
        frame(8'h6B, 24'h000010, 8'h00, 4, 0);
        cur_tag = "R4";
        frame(8'hEB, 24'h0000A3, 8'hFF, 3, 0);
        cur_tag = "R6";
        frame(8'h6B, 24'hAB00FD, 8'h00, 5, 0);
        frame(8'hEB, 24'h5700FE, 8'hF0, 4, 0);
        cur_tag = "R7";
        frame(8'hEB, 24'h000020, 8'hEF, 2, 0);
        frame(8'h00, 24'h000040, 8'h00, 2, 0);
        frame(8'h00, 24'h000081, 8'h10, 3, 0);
        cur_tag = "R8";
        frame(8'h6B, 24'h000033, 8'h00, 2, 0);
        frame(8'hEB, 24'h000044, 8'h00, 1, 0);
        frame(8'h00, 24'h000050, 8'hFF, 1, 0);
        frame(8'hEB, 24'h000060, 8'h00, 1, 0);
        frame(8'h00, 24'h000070, 8'h10, 1, 0);
        frame(8'h6B, 24'h000071, 8'h00, 1, 0);
        cur_tag = "R9";
        frame(8'hEB, 24'h000090, 8'hFF, 4, 2);
        frame(8'h6B, 24'h0000FE, 8'h00, 3, 1);
        cur_tag = "R10";
        frame(8'h03, 24'h000000, 8'h00, 0, 0);
        frame(8'h6B, 24'h000005, 8'h00, 2, 0);
        // R11: enter continuous mode, then cut a frame short in its address
        cur_tag = "R11";
        frame(8'hEB, 24'h000011, 8'h00, 1, 0);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 3; i++) tick(4'hA);
        end_frame();
        xip_m = 1'b0;
        frame(8'hEB, 24'h0000C8, 8'hFF, 2, 0);
        chk_on = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule